// File: doc/BRIEF.md
# UART Register Window with Receive Queue

This block is the bus side of a small UART. A processor sees four 32-bit words, selected by address bits [3:2], through a single-cycle access strobe. Index 0 returns the next received byte, index 1 takes a byte for transmission, index 2 is a read-only status word and index 3 is a control word. The read data is combinational and belongs to the cycle of the strobe. Any side effect of that access takes effect at the clock edge that ends the strobe.

Received bytes come in on a valid/data stream and wait in a queue of `RX_DEPTH` entries; the default is 8. Transmit bytes are held in a one-byte register and leave on a valid/ready stream. The serial line logic sits outside this block. Framing and parity error flags come from that logic as level inputs and are only shown in the status word. A sticky pending flag, combined with an enable bit in the control word, drives one level interrupt.

Top module: `uart_regif`

## Requirements
- R1: The word index is `acc_addr[3:2]`: 0 receive data, 1 transmit data, 2 status, 3 control. Reading control returns the last value written to control (bits 7:0). Reading transmit data returns the last byte written there. Read data above bit 7 is zero. After reset, status reads 0x04 and control reads 0.
- R2: Received bytes are stored first-in first-out, up to `RX_DEPTH` (8) of them. Status bit0 is 1 while at least one byte is stored. Status bit1 is 1 while the queue is full.
- R3: A byte that arrives while the queue is full is discarded, and status bit5 (overrun) becomes 1 and stays set.
- R4: A read of index 0 returns the oldest stored byte and removes it. On an empty queue, the read returns 0 and leaves the queue empty.
- R5: Writing control with bit1 set empties the queue and clears overrun. A byte arriving in that same cycle is discarded without setting overrun.
- R6: Writes to index 2 change nothing.
- R7: Status bit4 (pending) is set by a write to index 1 and is 1 whenever the queue is non-empty. A status read clears it, unless bytes remain stored.
- R8: `irq` is high exactly when pending is set and control bit4 is set.
- R9: A write to index 1 loads the byte into the holding register when it is empty, and `tx_vld` rises on the next cycle. The byte leaves on a cycle with `tx_vld` and `tx_rdy` both high. Status bit2 (transmit empty) is the inverse of `tx_vld`, and status bit3 (transmit full) equals `tx_vld`.
- R10: Writing control with bit0 set discards the held transmit byte, so `tx_vld` falls.
- R11: A write to index 1 while a byte is held and not leaving is not sent. A write in the same cycle that the held byte leaves replaces it.
- R12: Status bit6 shows `frame_err` and status bit7 shows `parity_err`.
- R13: An arrival and a receive read in the same cycle on a full queue return the oldest byte, discard the incoming one and set overrun. On a queue that is not full, both take effect and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Single-cycle access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| acc_wdata | input | DATA_W | Write data; bits 7:0 used |
| acc_rdata | output | DATA_W | Read data for the strobed access, 0 otherwise |
| rx_vld | input | 1 | Incoming byte valid |
| rx_byte | input | 8 | Incoming byte |
| tx_vld | output | 1 | Outgoing byte valid |
| tx_byte | output | 8 | Outgoing byte |
| tx_rdy | input | 1 | Downstream accepts outgoing byte |
| frame_err | input | 1 | Framing error flag from line logic |
| parity_err | input | 1 | Parity error flag from line logic |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a byte arrival and a receive-data read. The bench raises `rx_vld` in the same cycle as a read of index 0, once on a full queue and once on a queue holding seven bytes. It judges the result by the byte returned, the full and overrun status bits, and the complete order of the bytes drained afterwards. The second pair is a transmit write and the downstream handshake. The bench raises `tx_rdy` in the cycle of a second write while a byte is held, and expects the new byte on `tx_byte` afterwards.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int unsigned IDX_RXD  = 0;
  localparam int unsigned IDX_TXD  = 1;
  localparam int unsigned IDX_STAT = 2;
  localparam int unsigned IDX_CTRL = 3;

  localparam int unsigned CT_TXRST = 0;
  localparam int unsigned CT_RXRST = 1;
  localparam int unsigned CT_IE    = 4;

  // queue occupancy after one cycle
  function automatic int unsigned q_next_count(input int unsigned cnt,
                                               input logic push,
                                               input logic pop,
                                               input logic clr);
    int unsigned n;
    n = cnt;
    if (clr) n = 0;
    else begin
      if (push) n = n + 1;
      if (pop)  n = n - 1;
    end
    return n;
  endfunction

  // status word layout
  function automatic logic [7:0] pack_status(input logic rx_any,
                                             input logic rx_full,
                                             input logic tx_free,
                                             input logic tx_busy,
                                             input logic pend,
                                             input logic ovr,
                                             input logic ferr,
                                             input logic perr);
    return {perr, ferr, ovr, pend, tx_busy, tx_free, rx_full, rx_any};
  endfunction

endpackage

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt
);
  import uart_regif_pkg::*;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  // read position derived from write position and occupancy (DEPTH is a power of two)
  assign rd_ptr    = wr_ptr - PTR_W'(count);
  assign dout      = mem[rd_ptr];
  assign count_nxt = CNT_W'(q_next_count(32'(count), push, pop, clr));

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_nxt;
      if (clr)       wr_ptr <= '0;
      else if (push) wr_ptr <= wr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/uart_txhold.sv
module uart_txhold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [DW-1:0] din,
  input  logic          rdy,
  output logic          vld,
  output logic [DW-1:0] dout
);

  logic leaving;
  logic loading;

  assign leaving = vld && rdy;
  assign loading = wr && (!vld || leaving);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      dout <= '0;
    end else if (flush) begin
      vld <= 1'b0;
    end else if (loading) begin
      vld  <= 1'b1;
      dout <= din;
    end else if (leaving) begin
      vld <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_regif.sv
module uart_regif #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned RX_DEPTH = 8,
  localparam int unsigned BYTE_W  = 8,
  localparam int unsigned CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              rx_vld,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_vld,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_rdy,
  input  logic              frame_err,
  input  logic              parity_err,
  output logic              irq
);
  import uart_regif_pkg::*;

  logic [1:0]        idx;
  logic [BYTE_W-1:0] wbyte;
  logic              unused_bits;

  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] txd_q;
  logic              ovr_q;
  logic              pend_q;
  logic              ctrl_ie;

  logic [CNT_W-1:0]  rx_cnt;
  logic [CNT_W-1:0]  rx_cnt_nxt;
  logic [BYTE_W-1:0] rx_head;
  logic              rx_full;
  logic              rx_any;
  logic [BYTE_W-1:0] status_w;

  // named events, observed by the bound checker
  logic ev_rd_rx, ev_rd_stat, ev_wr_ctrl;
  logic ev_push, ev_drop, ev_pop, ev_rxrst;
  logic ev_txwr, ev_txrst, ev_txgo;

  assign idx         = acc_addr[3:2];
  assign wbyte       = acc_wdata[BYTE_W-1:0];
  assign unused_bits = ^{acc_wdata, acc_addr};

  assign ev_rd_rx   = acc_en && !acc_wr && (idx == 2'(IDX_RXD));
  assign ev_rd_stat = acc_en && !acc_wr && (idx == 2'(IDX_STAT));
  assign ev_wr_ctrl = acc_en &&  acc_wr && (idx == 2'(IDX_CTRL));
  assign ev_txwr    = acc_en &&  acc_wr && (idx == 2'(IDX_TXD));
  assign ev_rxrst   = ev_wr_ctrl && wbyte[CT_RXRST];
  assign ev_txrst   = ev_wr_ctrl && wbyte[CT_TXRST];

  assign rx_any  = (rx_cnt != '0);
  assign rx_full = (rx_cnt == CNT_W'(RX_DEPTH));

  assign ev_push = rx_vld && !rx_full && !ev_rxrst;
  assign ev_drop = rx_vld &&  rx_full && !ev_rxrst;
  assign ev_pop  = ev_rd_rx && rx_any;
  assign ev_txgo = tx_vld && tx_rdy;

  uart_rxq #(.DEPTH(RX_DEPTH), .DW(BYTE_W)) i_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ev_rxrst),
    .push      (ev_push),
    .pop       (ev_pop),
    .din       (rx_byte),
    .dout      (rx_head),
    .count     (rx_cnt),
    .count_nxt (rx_cnt_nxt)
  );

  uart_txhold #(.DW(BYTE_W)) i_txhold (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (ev_txrst),
    .wr    (ev_txwr),
    .din   (wbyte),
    .rdy   (tx_rdy),
    .vld   (tx_vld),
    .dout  (tx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      txd_q  <= '0;
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ev_wr_ctrl) ctrl_q <= wbyte;
      if (ev_txwr)    txd_q  <= wbyte;
      if (ev_rxrst)     ovr_q <= 1'b0;
      else if (ev_drop) ovr_q <= 1'b1;
      pend_q <= (pend_q && !ev_rd_stat) || ev_txwr || (rx_cnt_nxt != '0);
    end
  end

  assign ctrl_ie  = ctrl_q[CT_IE];
  assign irq      = pend_q && ctrl_ie;
  assign status_w = pack_status(rx_any, rx_full, !tx_vld, tx_vld,
                                pend_q, ovr_q, frame_err, parity_err);

  always_comb begin
    acc_rdata = '0;
    if (acc_en && !acc_wr) begin
      unique case (idx)
        2'(IDX_RXD):  acc_rdata = rx_any ? DATA_W'(rx_head) : '0;
        2'(IDX_TXD):  acc_rdata = DATA_W'(txd_q);
        2'(IDX_STAT): acc_rdata = DATA_W'(status_w);
        default:      acc_rdata = DATA_W'(ctrl_q);
      endcase
    end
  end

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             pend_q,
  input logic             ovr_q,
  input logic             ev_push,
  input logic             ev_drop,
  input logic             ev_pop,
  input logic             ev_rxrst,
  input logic             ev_txwr,
  input logic             ev_txrst,
  input logic             tx_vld,
  input logic             tx_rdy,
  input logic [7:0]       tx_byte
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(DEPTH)); // R2

  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |-> rx_cnt == CNT_W'(DEPTH)); // R3

  AST_OVR_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> ovr_q); // R3

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && !ev_push && !ev_rxrst) |=> rx_cnt == $past(rx_cnt) - 1'b1); // R4

  AST_RXRST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxrst |=> (rx_cnt == '0) && !ovr_q); // R5

  AST_PEND_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt != '0) |-> pend_q); // R7

  AST_PEND_AFTER_TXWR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txwr |=> pend_q); // R7

  AST_TX_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && !tx_rdy && !ev_txrst) |=> tx_vld && $stable(tx_byte)); // R9

  AST_TXRST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txrst |=> !tx_vld); // R10

endmodule

bind uart_regif uart_regif_chk #(.DEPTH(RX_DEPTH)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_cnt   (rx_cnt),
  .pend_q   (pend_q),
  .ovr_q    (ovr_q),
  .ev_push  (ev_push),
  .ev_drop  (ev_drop),
  .ev_pop   (ev_pop),
  .ev_rxrst (ev_rxrst),
  .ev_txwr  (ev_txwr),
  .ev_txrst (ev_txrst),
  .tx_vld   (tx_vld),
  .tx_rdy   (tx_rdy),
  .tx_byte  (tx_byte)
);

// File: tb/test_uart_regif.sv
`timescale 1ns/1ps
module test_uart_regif;

  localparam logic [3:0] A_RXD  = 4'h0;
  localparam logic [3:0] A_TXD  = 4'h4;
  localparam logic [3:0] A_STAT = 4'h8;
  localparam logic [3:0] A_CTRL = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        rx_vld = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_vld;
  logic [7:0]  tx_byte;
  logic        tx_rdy = 1'b0;
  logic        frame_err = 1'b0;
  logic        parity_err = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  uart_regif i_uart_regif (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .tx_vld(tx_vld), .tx_byte(tx_byte),
    .tx_rdy(tx_rdy), .frame_err(frame_err), .parity_err(parity_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(posedge clk); #1;
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    #1 d = acc_rdata;
    @(posedge clk); #1;
    acc_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_vld = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_vld = 1'b0;
  endtask

  // arrival and receive read in one cycle
  task automatic push_and_read(input logic [7:0] b, output logic [31:0] d);
    @(negedge clk);
    rx_vld = 1'b1; rx_byte = b;
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = A_RXD;
    #1 d = acc_rdata;
    @(posedge clk); #1;
    rx_vld = 1'b0; acc_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 tx_vld after reset", 32'(tx_vld), 0);
    rd(A_STAT, v); chk("R1 status after reset", v, 32'h04);
    rd(A_CTRL, v); chk("R1 control after reset", v, 0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    push(8'h11); push(8'h22); push(8'h33);
    rd(A_STAT, v); chk("R2 valid set, not full", v & 32'h3, 32'h1);
    rd(A_RXD, v); chk("R4 first byte", v, 32'h11);
    rd(A_RXD, v); chk("R4 second byte", v, 32'h22);
    rd(A_RXD, v); chk("R4 third byte", v, 32'h33);
    rd(A_RXD, v); chk("R4 empty read returns 0", v, 0);
    rd(A_STAT, v); chk("R4 empty read leaves empty", v & 32'h3, 0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    for (int i = 0; i < 9; i++) push(8'hA0 + 8'(i));
    rd(A_STAT, v); chk("R3 full, valid and overrun", v & 32'h23, 32'h23);
    for (int i = 0; i < 8; i++) begin
      rd(A_RXD, v); chk("R2 order after fill", v, 32'hA0 + 32'(i));
    end
    rd(A_STAT, v); chk("R3 overrun sticky when empty", v & 32'h21, 32'h20);
    wr(A_CTRL, 32'h02);
    rd(A_STAT, v); chk("R5 receive reset clears overrun", v & 32'h21, 0);
    wr(A_CTRL, 32'h00);
  endtask

  task automatic t_rxrst();
    logic [31:0] v;
    push(8'h01); push(8'h02); push(8'h03);
    wr(A_CTRL, 32'h12);
    rd(A_STAT, v); chk("R5 queue emptied", v & 32'h3, 0);
    rd(A_CTRL, v); chk("R5 control value stored", v, 32'h12);
    rd(A_RXD, v);  chk("R5 nothing left to read", v, 0);
    wr(A_CTRL, 32'h00);
  endtask

  task automatic t_stat_wr();
    logic [31:0] v;
    rd(A_STAT, v);
    wr(A_STAT, 32'hFF);
    rd(A_STAT, v); chk("R6 status write ignored", v, 32'h04);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(A_CTRL, 32'h10);
    rd(A_STAT, v);
    chk("R8 irq low, nothing pending", 32'(irq), 0);
    push(8'h55);
    chk("R7 R8 irq on received byte", 32'(irq), 1);
    rd(A_STAT, v); chk("R7 pending bit visible", v & 32'h10, 32'h10);
    chk("R7 pending kept while data stored", 32'(irq), 1);
    rd(A_RXD, v); chk("R4 byte read", v, 32'h55);
    chk("R7 pending sticky after pop", 32'(irq), 1);
    rd(A_STAT, v);
    chk("R7 status read clears pending", 32'(irq), 0);
    wr(A_CTRL, 32'h00);
    tx_rdy = 1'b1;
    wr(A_TXD, 32'h66);
    chk("R8 irq masked when disabled", 32'(irq), 0);
    wr(A_CTRL, 32'h10);
    chk("R8 irq on enable with pending from transmit", 32'(irq), 1);
    rd(A_STAT, v); chk("R7 pending from transmit write", v & 32'h10, 32'h10);
    chk("R7 cleared by status read", 32'(irq), 0);
    wr(A_CTRL, 32'h00);
    tx_rdy = 1'b0;
  endtask

  task automatic t_tx();
    logic [31:0] v;
    tx_rdy = 1'b0;
    wr(A_TXD, 32'h5A);
    chk("R9 tx_vld after write", 32'(tx_vld), 1);
    chk("R9 tx_byte", 32'(tx_byte), 32'h5A);
    rd(A_STAT, v); chk("R9 transmit full", v & 32'h0C, 32'h08);
    wr(A_TXD, 32'h33);
    chk("R11 held byte not replaced", 32'(tx_byte), 32'h5A);
    rd(A_TXD, v); chk("R1 transmit register readback", v, 32'h33);
    @(negedge clk); tx_rdy = 1'b1;
    @(posedge clk); #1; tx_rdy = 1'b0;
    chk("R9 byte left on handshake", 32'(tx_vld), 0);
    rd(A_STAT, v); chk("R9 transmit empty", v & 32'h0C, 32'h04);
    wr(A_TXD, 32'h11);
    @(negedge clk);
    tx_rdy = 1'b1;
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = A_TXD; acc_wdata = 32'h22;
    @(posedge clk); #1;
    acc_en = 1'b0; acc_wr = 1'b0; tx_rdy = 1'b0;
    chk("R11 replacement on leave cycle valid", 32'(tx_vld), 1);
    chk("R11 replacement byte", 32'(tx_byte), 32'h22);
    @(negedge clk); tx_rdy = 1'b1;
    @(posedge clk); #1; tx_rdy = 1'b0;
  endtask

  task automatic t_txrst();
    logic [31:0] v;
    wr(A_TXD, 32'h77);
    chk("R10 byte held", 32'(tx_vld), 1);
    wr(A_CTRL, 32'h01);
    chk("R10 held byte discarded", 32'(tx_vld), 0);
    rd(A_STAT, v); chk("R10 transmit empty again", v & 32'h0C, 32'h04);
    wr(A_CTRL, 32'h00);
  endtask

  task automatic t_err();
    logic [31:0] v;
    frame_err = 1'b1;
    rd(A_STAT, v); chk("R12 frame error bit6", v & 32'hC0, 32'h40);
    parity_err = 1'b1;
    rd(A_STAT, v); chk("R12 both error bits", v & 32'hC0, 32'hC0);
    frame_err = 1'b0;
    rd(A_STAT, v); chk("R12 parity error bit7", v & 32'hC0, 32'h80);
    parity_err = 1'b0;
  endtask

  task automatic t_coinc();
    logic [31:0] v;
    logic [7:0] exp_q [7];
    wr(A_CTRL, 32'h02); wr(A_CTRL, 32'h00);
    for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
    rd(A_STAT, v); chk("R2 full flag", v & 32'h2, 32'h2);
    push_and_read(8'hB0, v);
    chk("R13 oldest returned on full", v, 32'hA0);
    rd(A_STAT, v); chk("R13 incoming dropped, overrun", v & 32'h23, 32'h21);
    push_and_read(8'hB1, v);
    chk("R13 oldest returned on non-full", v, 32'hA1);
    rd(A_STAT, v); chk("R13 count unchanged, not full", v & 32'h23, 32'h21);
    for (int i = 0; i < 6; i++) exp_q[i] = 8'hA2 + 8'(i);
    exp_q[6] = 8'hB1;
    for (int i = 0; i < 7; i++) begin
      rd(A_RXD, v); chk("R13 drained order", v, 32'(exp_q[i]));
    end
    rd(A_STAT, v); chk("R13 empty after drain", v & 32'h1, 0);
    wr(A_CTRL, 32'h02); wr(A_CTRL, 32'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_order();
    t_full();
    t_rxrst();
    t_stat_wr();
    t_irq();
    t_tx();
    t_txrst();
    t_err();
    t_coinc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule